// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from peripherals and from the core, ranks them on a fixed ladder of sixteen priority levels, and hands the sequencer one level at a time together with the 32-bit start address of that level's service routine. It has two parts. The system part gates each peripheral request with an enable bit and places it on one of the lower core levels, using a programmable 4-bit assignment field for each peripheral. The core part latches requests per level, keeps track of which levels are being serviced, and presents the best candidate.

Level 0 has the highest priority and level 15 the lowest. Levels 0 to 6 are reachable only through direct core event inputs. Peripherals can be steered only to levels 7 to 15, and any number of peripherals may share one level. Software programs the masks, the assignments and the sixteen vectors through a single-cycle write port. The sequencer acknowledges the presented level, which moves that level from pending to active. A return strobe retires the most urgent active level. A new level interrupts the one being serviced only when it ranks above every active level, so handlers can nest.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset `irq_req` is low, every vector register reads as zero, every peripheral is enabled, and every core level is enabled.
- R2: A request on a level (a `core_evt` bit, or an enabled peripheral mapped to that level) that is high at a clock edge latches that level pending. When the level is eligible, `irq_req`, `irq_lvl` and `irq_vec` show it after that same edge and not before it.
- R3: When several eligible levels are pending, the level with the lowest index is presented.
- R4: `irq_vec` equals the vector register of the presented level. Vector register L is written at address L (0x00 to 0x0F) with the full 32-bit data word.
- R5: The system enable word at address 0x10 has bit p for peripheral p. When that bit is 0, requests from peripheral p are dropped and are not latched, so setting the bit again later raises nothing.
- R6: The assignment word at address 0x11 holds bits [4p+3:4p] as the level for peripheral p. After reset peripheral p maps to level 7+p. A field value below 7 is treated as level 15.
- R7: Peripherals that share a level raise that one level. A single acknowledge services all of them together.
- R8: The level enable word at address 0x12 has bit L for level L. A pending level whose bit is 0 is not presented but stays pending, and it is presented once its bit is set again.
- R9: When `irq_ack` is high while `irq_req` is high, the presented level is cleared from pending and becomes active at that edge. When `irq_ack` is high while `irq_req` is low, it has no effect.
- R10: A pending level is presented only when its index is lower than the index of every active level.
- R11: When `irq_ret` is high, the active level with the lowest index is cleared and all other active levels stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| periph_req | input | 8 | Peripheral interrupt requests, one per peripheral |
| core_evt | input | 16 | Direct core event requests, one per level |
| irq_ack | input | 1 | Sequencer accepts the presented level |
| irq_ret | input | 1 | Return from the current handler |
| irq_req | output | 1 | A level is presented to the sequencer |
| irq_lvl | output | 4 | Index of the presented level |
| irq_vec | output | 32 | Vector address of the presented level |

## Verification
A request that is high at a clock edge shows on `irq_req`, `irq_lvl` and `irq_vec` after that edge. Configuration writes, acknowledges and return strobes all take effect at the next edge, so each result is due one cycle after its stimulus. The bench drives every input on the falling edge and reads the outputs on the following falling edge. A queue holds the expected level and vector for each request. A monitor task pops the next entry only once the matching result is due, compares it, and then acknowledges it. Results that must not appear, such as a masked peripheral, a disabled level or a blocked nesting attempt, are checked in the same cycle in which they would otherwise have been presented.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned CFG_AW = 5;
   localparam logic [CFG_AW-1:0] ADDR_SYS_EN  = 5'h10;
   localparam logic [CFG_AW-1:0] ADDR_ASSIGN  = 5'h11;
   localparam logic [CFG_AW-1:0] ADDR_LVL_EN  = 5'h12;
endpackage

// File: rtl/intc_sys_map.sv
module intc_sys_map #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MAP_MIN    = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [intc_pkg::CFG_AW-1:0]      cfg_addr,
   input  logic [DATA_W-1:0]                cfg_wdata,
   input  logic [NUM_PERIPH-1:0]            periph_req,
   output logic [NUM_LEVELS-1:0]            lvl_req
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS);
   localparam int unsigned ASG_W = NUM_PERIPH * LVL_W;
   localparam logic [NUM_LEVELS-1:0] LOW_MASK = (NUM_LEVELS'(1) << MAP_MIN) - NUM_LEVELS'(1);

   function automatic logic [ASG_W-1:0] default_assign();
      logic [ASG_W-1:0] r;
      r = '0;
      for (int p = 0; p < int'(NUM_PERIPH); p++) begin
         int v;
         v = int'(MAP_MIN) + p;
         if (v > int'(NUM_LEVELS) - 1) v = int'(NUM_LEVELS) - 1;
         r[p*LVL_W +: LVL_W] = LVL_W'(v);
      end
      return r;
   endfunction

   logic [NUM_PERIPH-1:0] en_q;
   logic [ASG_W-1:0]      asg_q;
   logic [NUM_LEVELS-1:0] dec [NUM_PERIPH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '1;
         asg_q <= default_assign();
      end else if (cfg_we) begin
         if (cfg_addr == intc_pkg::ADDR_SYS_EN) en_q  <= cfg_wdata[NUM_PERIPH-1:0];
         if (cfg_addr == intc_pkg::ADDR_ASSIGN) asg_q <= cfg_wdata[ASG_W-1:0];
      end
   end

   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
      logic [LVL_W-1:0] fld;
      logic [LVL_W-1:0] eff;
      assign fld = asg_q[p*LVL_W +: LVL_W];
      assign eff = (int'(fld) < int'(MAP_MIN) || int'(fld) > int'(NUM_LEVELS) - 1)
                   ? LVL_W'(NUM_LEVELS - 1) : fld;
      assign dec[p] = (periph_req[p] && en_q[p]) ? (NUM_LEVELS'(1) << eff) : '0;
   end

   always_comb begin
      lvl_req = '0;
      for (int p = 0; p < int'(NUM_PERIPH); p++) lvl_req = lvl_req | dec[p];
   end

   // R6: peripherals never reach the levels reserved for the core
   a_r6_map_range: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_req & LOW_MASK) == '0);
endmodule

// File: rtl/intc_core_cfg.sv
module intc_core_cfg #(
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned VEC_W      = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [intc_pkg::CFG_AW-1:0]      cfg_addr,
   input  logic [DATA_W-1:0]                cfg_wdata,
   input  logic [$clog2(NUM_LEVELS)-1:0]    sel_lvl,
   output logic [VEC_W-1:0]                 sel_vec,
   output logic [NUM_LEVELS-1:0]            lvl_en
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS);

   logic [VEC_W-1:0] vec_q [NUM_LEVELS];

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_vec
      logic hit;
      assign hit = cfg_we && !cfg_addr[intc_pkg::CFG_AW-1]
                   && (int'(cfg_addr[LVL_W-1:0]) == l);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vec_q[l] <= '0;
         else if (hit) vec_q[l] <= cfg_wdata[VEC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_en <= '1;
      else if (cfg_we && cfg_addr == intc_pkg::ADDR_LVL_EN)
         lvl_en <= cfg_wdata[NUM_LEVELS-1:0];
   end

   assign sel_vec = vec_q[sel_lvl];
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
   parameter int unsigned NUM_LEVELS = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_LEVELS-1:0]            lvl_req,
   input  logic                             ack_fire,
   input  logic [$clog2(NUM_LEVELS)-1:0]    ack_lvl,
   input  logic                             ret,
   output logic [NUM_LEVELS-1:0]            pending,
   output logic [NUM_LEVELS-1:0]            active
);
   logic [NUM_LEVELS-1:0] ack_oh;
   logic [NUM_LEVELS-1:0] ret_oh;

   assign ack_oh = ack_fire ? (NUM_LEVELS'(1) << ack_lvl) : '0;
   assign ret_oh = ret ? (active & (~active + NUM_LEVELS'(1))) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= '0;
         active  <= '0;
      end else begin
         pending <= (pending & ~ack_oh) | lvl_req;
         active  <= (active & ~ret_oh) | ack_oh;
      end
   end

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_chk
      // R2: a request is always latched at its edge
      a_r2_pend_latch: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_req[l] |=> pending[l]);
   end

   // R9: an accepted level is active after the edge
   a_r9_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> (active & $past(ack_oh)) != '0);

   // R11: a return retires exactly one active level
   a_r11_ret_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !ack_fire && active != '0) |=>
         $countones(active) == $countones($past(active)) - 1);
endmodule

// File: rtl/intc_prio_sel.sv
module intc_prio_sel #(
   parameter int unsigned NUM_LEVELS = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_LEVELS-1:0]            cand,
   input  logic [NUM_LEVELS-1:0]            active,
   output logic                             valid,
   output logic [$clog2(NUM_LEVELS)-1:0]    lvl
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS);

   logic [NUM_LEVELS-1:0] act_or;
   logic [NUM_LEVELS-1:0] allow;
   logic [NUM_LEVELS-1:0] seen;
   logic [NUM_LEVELS-1:0] grant;

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign act_or[i] = active[i];
         assign allow[i]  = cand[i] & ~act_or[i];
         assign seen[i]   = allow[i];
         assign grant[i]  = allow[i];
      end else begin : g_rest
         assign act_or[i] = act_or[i-1] | active[i];
         assign allow[i]  = cand[i] & ~act_or[i];
         assign seen[i]   = seen[i-1] | allow[i];
         assign grant[i]  = allow[i] & ~seen[i-1];
      end
   end

   always_comb begin
      lvl = '0;
      for (int i = 0; i < int'(NUM_LEVELS); i++)
         if (grant[i]) lvl = LVL_W'(i);
   end
   assign valid = |grant;

   // R3: at most one level is granted
   a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned VEC_W      = 32,
   parameter int unsigned MAP_MIN    = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [4:0]                       cfg_addr,
   input  logic [31:0]                      cfg_wdata,
   input  logic [7:0]                       periph_req,
   input  logic [15:0]                      core_evt,
   input  logic                             irq_ack,
   input  logic                             irq_ret,
   output logic                             irq_req,
   output logic [3:0]                       irq_lvl,
   output logic [31:0]                      irq_vec
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS);

   initial begin
      if (NUM_LEVELS > 16 || NUM_LEVELS < 2) $fatal(1, "NUM_LEVELS out of range");
      if (MAP_MIN >= NUM_LEVELS)             $fatal(1, "MAP_MIN out of range");
      if (NUM_PERIPH * LVL_W > DATA_W)       $fatal(1, "assignment word too wide");
      if (VEC_W > DATA_W)                    $fatal(1, "vector wider than data");
   end

   logic [NUM_LEVELS-1:0] periph_lvl;
   logic [NUM_LEVELS-1:0] lvl_req;
   logic [NUM_LEVELS-1:0] pending;
   logic [NUM_LEVELS-1:0] active;
   logic [NUM_LEVELS-1:0] lvl_en;
   logic                  sel_valid;
   logic [LVL_W-1:0]      sel_lvl;
   logic [VEC_W-1:0]      sel_vec;
   logic                  ack_fire;

   intc_sys_map #(.NUM_PERIPH(NUM_PERIPH), .NUM_LEVELS(NUM_LEVELS),
                  .DATA_W(DATA_W), .MAP_MIN(MAP_MIN)) u_map (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .periph_req(periph_req), .lvl_req(periph_lvl));

   intc_core_cfg #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sel_lvl(sel_lvl), .sel_vec(sel_vec), .lvl_en(lvl_en));

   assign lvl_req  = periph_lvl | core_evt[NUM_LEVELS-1:0];
   assign ack_fire = irq_ack & sel_valid;

   intc_pend #(.NUM_LEVELS(NUM_LEVELS)) u_pend (
      .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .ack_fire(ack_fire),
      .ack_lvl(sel_lvl), .ret(irq_ret), .pending(pending), .active(active));

   intc_prio_sel #(.NUM_LEVELS(NUM_LEVELS)) u_sel (
      .clk(clk), .rst_n(rst_n), .cand(pending & lvl_en), .active(active),
      .valid(sel_valid), .lvl(sel_lvl));

   assign irq_req = sel_valid;
   assign irq_lvl = 4'(sel_lvl);
   assign irq_vec = 32'(sel_vec);

   // R10: a presented level outranks every level in service
   a_r10_nest_rank: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (active & ((NUM_LEVELS'(1) << (sel_lvl + 1'b1)) - NUM_LEVELS'(1))) == '0);
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [7:0]  periph_req = '0;
   logic [15:0] core_evt = '0;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic        irq_req;
   logic [3:0]  irq_lvl;
   logic [31:0] irq_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed { logic [3:0] lvl; logic [31:0] vec; } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   prio_vec_intc dut (.*);

   function automatic logic [31:0] vec_of(input int l);
      return 32'h8000_0000 + 32'(l) * 32'h40;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] ev, input logic [7:0] pr);
      core_evt = ev; periph_req = pr;
      step();
      core_evt = '0; periph_req = '0;
   endtask

   task automatic expect_irq(input int l, input logic [31:0] v);
      exp_q.push_back({4'(l), v});
   endtask

   task automatic take(input string tag);
      exp_t e;
      e = exp_q.pop_front();
      chk({tag, " req"}, 32'(irq_req), 32'd1);
      chk({tag, " lvl"}, 32'(irq_lvl), 32'(e.lvl));
      chk({tag, " vec"}, irq_vec, e.vec);
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
   endtask

   task automatic ret();
      irq_ret = 1'b1;
      step();
      irq_ret = 1'b0;
   endtask

   task automatic quiet(input string tag);
      chk({tag, " no irq"}, 32'(irq_req), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      quiet("R1 reset");

      // R1: vectors are zero after reset; R2: not presented before the edge
      core_evt = 16'h0002;
      #1 quiet("R2 before edge");
      step();
      core_evt = '0;
      expect_irq(1, 32'h0);
      take("R1 reset vector");
      ret();
      quiet("R11 idle after return");

      for (int l = 0; l < 16; l++) wr(5'(l), vec_of(l));

      // R6: default mapping, peripheral 3 -> level 10; R4 vector
      pulse(16'h0, 8'h08);
      expect_irq(10, vec_of(10));
      take("R6 default map R4");
      ret();

      // R3: priority among simultaneous levels 5, 7, 12; R10 blocking
      pulse(16'h1020, 8'h01);
      expect_irq(5, vec_of(5));
      take("R3 highest first");
      quiet("R10 lower blocked");
      ret();
      expect_irq(7, vec_of(7));
      take("R3 second");
      quiet("R10 level 12 blocked");
      ret();
      expect_irq(12, vec_of(12));
      take("R3 third");
      ret();
      quiet("R9 all serviced");

      // R10: preemption by a higher level while 7 is active
      pulse(16'h0, 8'h01);
      expect_irq(7, vec_of(7));
      take("R10 base");
      pulse(16'h0008, 8'h0);
      expect_irq(3, vec_of(3));
      take("R10 preempt");
      ret();
      quiet("R11 after inner return");
      ret();
      quiet("R11 after outer return");

      // R5: system enable
      wr(5'h10, 32'h0000_00FB);
      pulse(16'h0, 8'h04);
      quiet("R5 masked peripheral");
      wr(5'h10, 32'h0000_00FF);
      quiet("R5 no latch while masked");

      // R6 remap, R7 sharing, clamp
      wr(5'h11, 32'hED39_A997);
      pulse(16'h0, 8'h12);
      expect_irq(9, vec_of(9));
      take("R7 shared level");
      quiet("R7 single service");
      ret();
      pulse(16'h0, 8'h20);
      expect_irq(15, vec_of(15));
      take("R6 clamp to 15");
      ret();

      // R8: level enable keeps pending
      wr(5'h12, 32'h0000_FEFF);
      pulse(16'h0100, 8'h0);
      quiet("R8 disabled level");
      wr(5'h12, 32'h0000_FFFF);
      expect_irq(8, vec_of(8));
      take("R8 re-enabled");
      ret();

      // R9: acknowledge while idle is ignored
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
      pulse(16'h0010, 8'h0);
      expect_irq(4, vec_of(4));
      take("R9 idle ack ignored");
      ret();
      quiet("R9 no stray active");

      // R11: return clears only the most urgent active level
      pulse(16'h0, 8'h01);
      expect_irq(7, vec_of(7));
      take("R11 level 7");
      pulse(16'h0004, 8'h0);
      expect_irq(2, vec_of(2));
      take("R11 level 2");
      pulse(16'h0001, 8'h0);
      expect_irq(0, vec_of(0));
      take("R11 level 0");
      ret();
      pulse(16'h0002, 8'h0);
      expect_irq(1, vec_of(1));
      take("R11 level 0 retired");
      ret();
      pulse(16'h0008, 8'h0);
      quiet("R11 level 2 still active");
      ret();
      expect_irq(3, vec_of(3));
      take("R11 level 2 retired");
      ret();
      ret();
      quiet("R11 all retired");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule